// File: doc/BRIEF.md
# Hex Error-Report Serializer

This block turns one memory-test failure into a line of printable text. It takes a record made of a 16-bit address, the 8-bit pattern that was written and the 8-bit value read back. It then sends that record out one ASCII character at a time to a character sink such as a serial transmitter. Each byte becomes two uppercase hex digits. The address comes first, then the pattern, then the observed value. Each pair of fields is separated by two spaces, and the line ends with carriage return and line feed. A separate request sends a bare line break, which a test sequencer uses when a new test begins.

Both inputs use a valid/ready handshake, and so does the character output. The block holds one record at a time. It accepts nothing new until the last character of the current line has been taken. When a line-break request and a record are offered in the same cycle, the line break goes out first.

Top module: `hexrep_ser`

## Requirements
- R1: After reset, `chr_valid` is low and both `rec_ready` and `brk_ready` are high.
- R2: An accepted record produces exactly 14 characters in this order: four address digits (most significant nibble first), 0x20, 0x20, two pattern digits, 0x20, 0x20, two observed-value digits, 0x0D, 0x0A. After the 0x0A is taken, `chr_valid` drops.
- R3: Each byte is sent as two digits, upper nibble first. A nibble n becomes 0x30|n, and 7 is added when that value is 0x3A or more. So 0–9 map to 0x30–0x39 and 10–15 map to 0x41–0x46.
- R4: An accepted line-break request produces only 0x0D and then 0x0A.
- R5: While a line is in progress (`chr_valid` high), `rec_ready` and `brk_ready` are both low.
- R6: While `chr_valid` is high and `chr_ready` is low, `chr_data` and `chr_valid` hold their values into the next cycle.
- R7: When `brk_valid` and `rec_valid` are both high while the block is idle, only the line break is accepted (`brk_ready` high, `rec_ready` low). Its 0x0D 0x0A are sent before any character of the record.
- R8: The record fields are captured when the record is accepted. Changes on `rec_addr`, `rec_expect` or `rec_seen` after that do not alter the line being sent.
- R9: The first character of a line appears on `chr_valid` in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rec_valid | input | 1 | Error record offered |
| rec_ready | output | 1 | Error record accepted this cycle when high with `rec_valid` |
| rec_addr | input | 16 | Failing address |
| rec_expect | input | 8 | Pattern that was written |
| rec_seen | input | 8 | Value that was read back |
| brk_valid | input | 1 | Request for a bare line break |
| brk_ready | output | 1 | Line-break request accepted when high with `brk_valid` |
| chr_valid | output | 1 | Character available |
| chr_ready | input | 1 | Sink takes the character |
| chr_data | output | 8 | ASCII character |

## Verification
The assertions assume the sink obeys the output handshake. They also assume that a source offering a record or a line break keeps that offer up until it sees the matching ready signal. Stability under back-pressure is checked only on the block's own output. The bench drives every request from the falling edge and holds it until it sees the ready signal. It changes the record fields only after acceptance, which is also how it checks R8. It switches the sink between always-ready and a sparse-ready pattern so that stalls land on every kind of character.

// File: rtl/hexrep_pkg.sv
// Shared constants and types for the hex error-report serializer.
// Assumes 8-bit data bytes and 4-bit hex digits; the address width is a
// parameter of the top module.
package hexrep_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    localparam logic [BYTE_W-1:0] CH_SPACE = 8'h20;
    localparam logic [BYTE_W-1:0] CH_CR    = 8'h0D;
    localparam logic [BYTE_W-1:0] CH_LF    = 8'h0A;

    // Character count of one line for a given address width.
    function automatic int line_chars(input int addr_w);
        return (addr_w / NIB_W) + 2 + 2 + 2 + 2 + 2;
    endfunction
endpackage

// File: rtl/hexrep_digit.sv
// Converts one 4-bit nibble to an uppercase ASCII hex digit.
// Method: OR with 0x30, then add 7 when the result passes 0x39.
// Purely combinational; assumes nothing about its input.
module hexrep_digit
    import hexrep_pkg::*;
(
    input  logic [NIB_W-1:0]  nib,
    output logic [BYTE_W-1:0] ch
);
    logic [BYTE_W-1:0] base;

    // Form the decimal-range code and shift letters past the punctuation gap.
    always_comb begin
        base = 8'h30 | {4'h0, nib};
        ch   = (base >= 8'h3A) ? base + 8'd7 : base;
        assert (((ch >= 8'h30) && (ch <= 8'h39)) || ((ch >= 8'h41) && (ch <= 8'h46))); // R3
    end
endmodule

// File: rtl/hexrep_ctrl.sv
// Handshake and sequencing control for the serializer.
// Holds one captured record and a character index. A line-break request
// starts the index at the CR slot; a record starts it at zero.
// Assumes the sources hold valid until they see ready.
module hexrep_ctrl
    import hexrep_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int CHARS = line_chars(ADDR_W),
    localparam int IDX_W = $clog2(CHARS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [BYTE_W-1:0] rec_expect,
    input  logic [BYTE_W-1:0] rec_seen,
    input  logic              brk_valid,
    input  logic              chr_ready,
    output logic              rec_ready,
    output logic              brk_ready,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [BYTE_W-1:0] cap_expect,
    output logic [BYTE_W-1:0] cap_seen
);
    localparam logic [IDX_W-1:0] CR_IDX = IDX_W'(CHARS - 2);
    localparam logic [IDX_W-1:0] LF_IDX = IDX_W'(CHARS - 1);

    logic last_take;

    // Ready only when idle; a pending line break blocks the record.
    always_comb begin
        brk_ready = !busy;
        rec_ready = !busy && !brk_valid;
        last_take = busy && chr_ready && (idx == LF_IDX);
    end

    // Accept requests, capture the record, and step through characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            idx        <= '0;
            cap_addr   <= '0;
            cap_expect <= '0;
            cap_seen   <= '0;
        end else if (!busy) begin
            if (brk_valid) begin
                busy <= 1'b1;
                idx  <= CR_IDX;
            end else if (rec_valid) begin
                busy       <= 1'b1;
                idx        <= '0;
                cap_addr   <= rec_addr;
                cap_expect <= rec_expect;
                cap_seen   <= rec_seen;
            end
        end else if (chr_ready) begin
            if (idx == LF_IDX) busy <= 1'b0;
            else               idx  <= idx + 1'b1;
        end
    end

    AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last_take |=> $stable(cap_addr) && $stable(cap_expect) && $stable(cap_seen)); // R8
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx <= LF_IDX)); // R2
    AST_LINE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> !busy); // R2
endmodule

// File: rtl/hexrep_pick.sv
// Chooses the character for the current index: an address, pattern or
// observed-value digit, a space, CR or LF. The digit is produced by a
// shared nibble converter. Combinational; assumes idx < line length.
module hexrep_pick
    import hexrep_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int CHARS  = line_chars(ADDR_W),
    localparam int IDX_W  = $clog2(CHARS),
    localparam int ADIGS  = ADDR_W / NIB_W
)(
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [BYTE_W-1:0] cap_expect,
    input  logic [BYTE_W-1:0] cap_seen,
    output logic [BYTE_W-1:0] ch
);
    logic [NIB_W-1:0]  nib;
    logic [BYTE_W-1:0] hex_ch;
    logic              is_hex;
    logic [BYTE_W-1:0] fixed_ch;
    int                rel;

    hexrep_digit u_digit (.nib(nib), .ch(hex_ch));

    // Map the index onto a field nibble or a fixed character.
    always_comb begin
        nib      = '0;
        is_hex   = 1'b0;
        fixed_ch = CH_SPACE;
        rel      = int'(idx) - ADIGS;
        if (int'(idx) < ADIGS) begin
            is_hex = 1'b1;
            nib    = NIB_W'(cap_addr >> (NIB_W * (ADIGS - 1 - int'(idx))));
        end else begin
            case (rel)
                2:       begin is_hex = 1'b1; nib = cap_expect[7:4]; end
                3:       begin is_hex = 1'b1; nib = cap_expect[3:0]; end
                6:       begin is_hex = 1'b1; nib = cap_seen[7:4];   end
                7:       begin is_hex = 1'b1; nib = cap_seen[3:0];   end
                8:       fixed_ch = CH_CR;
                9:       fixed_ch = CH_LF;
                default: fixed_ch = CH_SPACE;
            endcase
        end
    end

    // Final output mux between converted digit and fixed character.
    always_comb begin
        ch = is_hex ? hex_ch : fixed_ch;
    end
endmodule

// File: rtl/hexrep_ser.sv
// Top of the hex error-report serializer. Accepts an error record or a
// bare line-break request and streams the resulting ASCII line to a
// character sink, one character per valid/ready beat.
// Assumes the sink and the sources follow valid/ready rules.
module hexrep_ser
    import hexrep_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int CHARS = line_chars(ADDR_W),
    localparam int IDX_W = $clog2(CHARS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [BYTE_W-1:0] rec_expect,
    input  logic [BYTE_W-1:0] rec_seen,
    input  logic              brk_valid,
    output logic              brk_ready,
    output logic              chr_valid,
    input  logic              chr_ready,
    output logic [BYTE_W-1:0] chr_data
);
    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] cap_addr;
    logic [BYTE_W-1:0] cap_expect;
    logic [BYTE_W-1:0] cap_seen;

    hexrep_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_addr(rec_addr),
        .rec_expect(rec_expect), .rec_seen(rec_seen),
        .brk_valid(brk_valid), .chr_ready(chr_ready),
        .rec_ready(rec_ready), .brk_ready(brk_ready),
        .busy(busy), .idx(idx),
        .cap_addr(cap_addr), .cap_expect(cap_expect), .cap_seen(cap_seen)
    );

    hexrep_pick #(.ADDR_W(ADDR_W)) u_pick (
        .idx(idx), .cap_addr(cap_addr), .cap_expect(cap_expect),
        .cap_seen(cap_seen), .ch(chr_data)
    );

    // Output is valid for the whole of a line in progress.
    always_comb begin
        chr_valid = busy;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !chr_ready |=> chr_valid && $stable(chr_data)); // R6
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |-> !rec_ready && !brk_ready); // R5
    AST_BRK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_valid && brk_valid && rec_valid |=> chr_valid && (chr_data == CH_CR)); // R7
    AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && rec_ready |=> chr_valid); // R9
    AST_LF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && chr_ready && (chr_data == CH_LF) |=> !chr_valid); // R2
endmodule

// File: tb/hexrep_ser_bench.sv
// Scoreboard bench: drivers push expected characters, a monitor pops and
// compares them against the sink side of the serializer.
module hexrep_ser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [15:0] rec_addr = '0;
    logic [7:0]  rec_expect = '0;
    logic [7:0]  rec_seen = '0;
    logic        brk_valid = 1'b0;
    logic        brk_ready;
    logic        chr_valid;
    logic        chr_ready = 1'b1;
    logic [7:0]  chr_data;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    int stall_mode = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    hexrep_ser u_hexrep_ser (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_addr(rec_addr), .rec_expect(rec_expect), .rec_seen(rec_seen),
        .brk_valid(brk_valid), .brk_ready(brk_ready),
        .chr_valid(chr_valid), .chr_ready(chr_ready), .chr_data(chr_data)
    );

    function automatic logic [7:0] hexch(input logic [3:0] n);
        return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h41 + ({4'h0, n} - 8'd10);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c, input string tag);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    task automatic push_line(input logic [15:0] a, input logic [7:0] p, input logic [7:0] s, input string tag);
        push(hexch(a[15:12]), tag); push(hexch(a[11:8]), tag);
        push(hexch(a[7:4]), tag);   push(hexch(a[3:0]), tag);
        push(8'h20, tag); push(8'h20, tag);
        push(hexch(p[7:4]), tag); push(hexch(p[3:0]), tag);
        push(8'h20, tag); push(8'h20, tag);
        push(hexch(s[7:4]), tag); push(hexch(s[3:0]), tag);
        push(8'h0D, tag); push(8'h0A, tag);
    endtask

    // Offer a record, wait for acceptance, optionally scramble fields (R8).
    task automatic send_record(input logic [15:0] a, input logic [7:0] p, input logic [7:0] s,
                               input string tag, input bit garble);
        @(negedge clk);
        rec_addr = a; rec_expect = p; rec_seen = s; rec_valid = 1'b1;
        forever begin
            #2;
            if (rec_ready) break;
            @(negedge clk);
        end
        push_line(a, p, s, tag);
        @(negedge clk);
        rec_valid = 1'b0;
        if (garble) begin
            rec_addr = ~a; rec_expect = ~p; rec_seen = ~s;
        end
        #2;
        check(chr_valid === 1'b1, "R9", chr_valid, 1);
    endtask

    task automatic send_break();
        @(negedge clk);
        brk_valid = 1'b1;
        forever begin
            #2;
            if (brk_ready) break;
            @(negedge clk);
        end
        push(8'h0D, "R4"); push(8'h0A, "R4");
        @(negedge clk);
        brk_valid = 1'b0;
    endtask

    // Both requests at once: line break must win (R7).
    task automatic send_both(input logic [15:0] a, input logic [7:0] p, input logic [7:0] s);
        @(negedge clk);
        rec_addr = a; rec_expect = p; rec_seen = s;
        rec_valid = 1'b1; brk_valid = 1'b1;
        #2;
        check(brk_ready && !rec_ready, "R7", {brk_ready, rec_ready}, 2'b10);
        push(8'h0D, "R7"); push(8'h0A, "R7");
        @(negedge clk);
        brk_valid = 1'b0;
        forever begin
            #2;
            if (rec_ready) break;
            @(negedge clk);
        end
        push_line(a, p, s, "R7");
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || chr_valid) @(negedge clk);
    endtask

    // Monitor: set sink readiness, then compare handshakes and stall holds.
    initial begin
        logic       prev_stall = 1'b0;
        logic [7:0] prev_data  = '0;
        forever begin
            @(negedge clk);
            cycle++;
            chr_ready = (stall_mode == 0) ? 1'b1 : ((cycle % 3) == 0);
            #1;
            if (rst_n) begin
                if (chr_valid) begin
                    check(!rec_ready && !brk_ready, "R5", {rec_ready, brk_ready}, 0);
                    if (prev_stall) check(chr_data == prev_data, "R6", chr_data, prev_data);
                end else if (prev_stall) begin
                    check(1'b0, "R6", chr_valid, 1);
                end
                if (chr_valid && chr_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", chr_data, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(chr_data == e, t, chr_data, e);
                    end
                end
                prev_stall = chr_valid && !chr_ready;
                prev_data  = chr_data;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!chr_valid && rec_ready && brk_ready, "R1", {chr_valid, rec_ready, brk_ready}, 3'b011);

        // R2/R3: all-zero and all-one digits, mixed letters.
        send_record(16'h0000, 8'h00, 8'hFF, "R2", 1'b0);
        drain();
        send_record(16'hA5C3, 8'h3C, 8'h9A, "R3", 1'b0);
        drain();
        send_break();           // R4
        drain();
        stall_mode = 1;         // R6 under back-pressure
        send_record(16'h1234, 8'h56, 8'h78, "R6", 1'b0);
        drain();
        send_record(16'hFEDB, 8'hE2, 8'h0E, "R8", 1'b1);
        drain();
        send_both(16'hBEEF, 8'hF2, 8'h01);
        drain();
        stall_mode = 0;
        send_both(16'h7F80, 8'hA9, 8'h3B);
        drain();
        send_record(16'hFFFF, 8'hF2, 8'h00, "R2", 1'b1);
        drain();

        repeat (3) @(negedge clk);
        #2;
        check(exp_q.size() == 0 && !chr_valid, "R2", exp_q.size(), 0);
        check(rec_ready && brk_ready, "R1", {rec_ready, brk_ready}, 3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule